// File: doc/BRIEF.md
# Coin-Pair Same-Face Detector

This block watches a serial stream of coin tosses and reports when two tosses in a row, taken as a pair, landed on the same face. One toss arrives on each clock cycle where the strobe is high. The face bit is 1 for a head and 0 for a tail. Tosses are grouped into back-to-back pairs, starting from the first toss after reset.

When the second toss of a pair is accepted, one of two flags may rise. The heads flag rises if both tosses were heads. The tails flag rises if both were tails. A mixed pair raises neither flag.

The next accepted toss always drops both flags, whatever face it shows. That toss also opens the following pair as its first toss. The flags are decoded from the state register alone, so they change only at a clock edge that accepts a toss, or at reset.

Top module: `coin_pair_detector`

## Requirements
- R1: After reset both flags are 0, and the next accepted toss is taken as the first toss of a new pair.
- R2: On the clock edge that accepts a second toss, if both tosses of the pair were heads (face 1), the heads flag is 1 from that edge on.
- R3: On the clock edge that accepts a second toss, if both tosses of the pair were tails (face 0), the tails flag is 1 from that edge on.
- R4: A pair of one head and one tail, in either order, leaves both flags 0.
- R5: The first accepted toss after a completed pair clears both flags at that edge, whether the toss is a head or a tail.
- R6: The toss that clears the flags is also the first toss of the next pair, so the toss after it completes that pair.
- R7: On cycles with the strobe low, the face input is ignored, and the flags and the pair position hold.
- R8: The heads flag and the tails flag are never 1 together.
- R9: Asserting reset in the middle of a pair discards the pending first toss and restarts the pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| toss_vld | input | 1 | Strobe: a toss is presented on this cycle |
| toss_face | input | 1 | Face of the toss: 1 for a head, 0 for a tail |
| pair_heads | output | 1 | Last completed pair was two heads |
| pair_tails | output | 1 | Last completed pair was two tails |

## Verification
The flags are the only outputs. A wrong internal state therefore shows at the ports only when it changes a flag.

A slipped pair boundary stays hidden until the next same-face pair. That pair then raises its flag one accepted toss early or late, or not at all. A state that loses its first-toss face gives the wrong flag on the very next accepted toss. A state that moves on a stalled cycle shifts every later pair, so long random streams with gaps in the strobe expose it within a few pairs.

// File: rtl/coin_pair_pkg.sv
package coin_pair_pkg;

  typedef enum logic [2:0] {
    ST_START   = 3'd0,
    ST_FIRST_H = 3'd1,
    ST_FIRST_T = 3'd2,
    ST_PAIR_HH = 3'd3,
    ST_PAIR_TT = 3'd4,
    ST_PAIR_MX = 3'd5
  } pair_state_e;

  function automatic logic is_pair_done(pair_state_e s);
    return (s == ST_PAIR_HH) || (s == ST_PAIR_TT) || (s == ST_PAIR_MX);
  endfunction

endpackage

// File: rtl/coin_pair_fsm.sv
module coin_pair_fsm
  import coin_pair_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        toss_vld,
  input  logic        toss_face,
  output pair_state_e state_q
);

  pair_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (toss_vld) begin
      unique case (state_q)
        ST_FIRST_H: state_d = toss_face ? ST_PAIR_HH : ST_PAIR_MX;
        ST_FIRST_T: state_d = toss_face ? ST_PAIR_MX : ST_PAIR_TT;
        default:    state_d = toss_face ? ST_FIRST_H : ST_FIRST_T;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
    end else if (toss_vld) begin
      state_q <= state_d;
    end
  end

  // R7: no movement without a strobe
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !toss_vld |=> $stable(state_q));

  // R2: head after a first head completes a heads pair
  p_heads_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (toss_vld && toss_face && state_q == ST_FIRST_H) |=> state_q == ST_PAIR_HH);

  // R3: tail after a first tail completes a tails pair
  p_tails_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (toss_vld && !toss_face && state_q == ST_FIRST_T) |=> state_q == ST_PAIR_TT);

  // R6: toss after a completed pair opens the next pair
  p_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (toss_vld && is_pair_done(state_q)) |=>
      (state_q == ST_FIRST_H || state_q == ST_FIRST_T));

endmodule

// File: rtl/coin_pair_decode.sv
module coin_pair_decode
  import coin_pair_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        toss_vld,
  input  pair_state_e state_q,
  output logic        pair_heads,
  output logic        pair_tails
);

  always_comb begin
    pair_heads = (state_q == ST_PAIR_HH);
    pair_tails = (state_q == ST_PAIR_TT);
  end

  // R8: flags mutually exclusive
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pair_heads && pair_tails));

  // R5: any toss after a completed pair clears both flags
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (toss_vld && is_pair_done(state_q)) |=> (!pair_heads && !pair_tails));

endmodule

// File: rtl/coin_pair_detector.sv
module coin_pair_detector
  import coin_pair_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic toss_vld,
  input  logic toss_face,
  output logic pair_heads,
  output logic pair_tails
);

  pair_state_e state_q;

  coin_pair_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .toss_vld  (toss_vld),
    .toss_face (toss_face),
    .state_q   (state_q)
  );

  coin_pair_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .toss_vld   (toss_vld),
    .state_q    (state_q),
    .pair_heads (pair_heads),
    .pair_tails (pair_tails)
  );

endmodule

// File: tb/coin_pair_detector_tb_top.sv
module coin_pair_detector_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic toss_vld = 1'b0;
  logic toss_face = 1'b0;
  logic pair_heads, pair_tails;

  int n_checks = 0;
  int n_errors = 0;

  // bench reference model
  bit   m_have_first = 1'b0;
  bit   m_first = 1'b0;
  bit   m_h = 1'b0;
  bit   m_t = 1'b0;

  always #4 clk = ~clk;

  coin_pair_detector dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .toss_vld   (toss_vld),
    .toss_face  (toss_face),
    .pair_heads (pair_heads),
    .pair_tails (pair_tails)
  );

  function automatic bit exp_heads(bit first, bit second);
    return first && second;
  endfunction

  function automatic bit exp_tails(bit first, bit second);
    return !first && !second;
  endfunction

  task automatic model_reset();
    m_have_first = 1'b0;
    m_h = 1'b0;
    m_t = 1'b0;
  endtask

  task automatic model_toss(bit f);
    if (m_have_first) begin
      m_h = exp_heads(m_first, f);
      m_t = exp_tails(m_first, f);
      m_have_first = 1'b0;
    end else begin
      m_first = f;
      m_have_first = 1'b1;
      m_h = 1'b0;
      m_t = 1'b0;
    end
  endtask

  task automatic check(string req, bit act_h, bit act_t, bit e_h, bit e_t);
    n_checks++;
    if (act_h !== e_h || act_t !== e_t) begin
      n_errors++;
      $display("FAIL %s: heads/tails actual=%0b%0b expected=%0b%0b",
               req, act_h, act_t, e_h, e_t);
    end
  endtask

  // drive on falling edge, sample 1 ns after the rising edge
  task automatic step(bit v, bit f, string req);
    @(negedge clk);
    toss_vld = v;
    toss_face = f;
    @(posedge clk);
    if (v) model_toss(f);
    #1;
    check(req, pair_heads, pair_tails, m_h, m_t);
    n_checks++;
    if (pair_heads && pair_tails) begin
      n_errors++;
      $display("FAIL R8: heads/tails actual=11 expected=not both");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    toss_vld = 1'b0;
    model_reset();
    #1;
    check("R1", pair_heads, pair_tails, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #1000000;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20251));
    do_reset();
    check("R1", pair_heads, pair_tails, 1'b0, 1'b0);
    // R2 heads pair, then R5 clear with a head
    step(1, 1, "R1"); step(1, 1, "R2"); step(1, 1, "R5");
    // R6: that head plus a head completes the next pair
    step(1, 1, "R6");
    // R5 clear with a tail
    step(1, 0, "R5");
    step(1, 0, "R3");
    // R7: stalls with face toggling hold the flag
    step(0, 1, "R7"); step(0, 0, "R7"); step(0, 1, "R7");
    step(1, 0, "R5");
    step(1, 1, "R4");   // tail then head
    step(1, 1, "R5");
    step(1, 0, "R4");   // head then tail
    // R7: stall inside a pair keeps alignment
    step(1, 1, "R6"); step(0, 0, "R7"); step(1, 1, "R2");
    // R9: reset mid pair discards first toss
    step(1, 0, "R5");
    do_reset();
    step(1, 1, "R9"); step(1, 1, "R9");
    // random stream
    for (int i = 0; i < 2000; i++) begin
      if (($urandom % 97) == 0) do_reset();
      else step(($urandom % 10) < 7, $urandom % 2, "R2/R3/R4/R5/R7");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule